// File: doc/BRIEF.md
# Stepper Microstep Sequencer

This block sequences the coil currents of a two-phase bipolar stepper motor. It holds an electrical position counter of 256 positions per electrical cycle. Each rising edge of a step-clock input moves the counter one step forward or back, and the block derives from it a 6-bit magnitude code and a polarity bit for each phase. Phase A follows a sine-shaped quarter-wave table. Phase B is the same curve shifted a quarter cycle ahead.

Two resolutions are available: a fine mode that walks all 256 positions, and a coarse half-step mode that takes eight positions per cycle at 0%, 71% and 100% of full scale. An enable input blanks the outputs while the counter keeps following step edges. A park input returns the counter to the initial position and holds it there. An active-low monitor pulse marks each full electrical turn, or each quarter turn. A strobe flags every step that lowers either phase magnitude, for use by a fast-decay controller downstream. All state advances only on cycles where the `tick` enable is high.

Top module: `microstep_seq`

## Requirements
- R1: After `rst_n` is low, the position is 0. With `enable` high, this shows `mag_a`=2, `neg_a`=0, `mag_b`=63, `neg_b`=0, `mon_n`=1 and `step_down`=0.
- R2: The position changes only on a clock edge with `tick` high where `step_clk` is 1 and was 0 at the previous tick. A high `step_clk` without `tick`, or a tick without a new rising edge, leaves the outputs unchanged.
- R3: With `dir`=0 each step adds the stride to the position, and with `dir`=1 it subtracts the stride. The position wraps modulo 256.
- R4: In fine mode (`coarse`=0) the stride is 1. For a position p, i = p[5:0] when p[6]=0, and 63-p[5:0] when p[6]=1. The quarter-percent value q(i) is:
  - 10(i+1) for i≤7
  - 80+9(i-7) up to 23
  - 224+7(i-23) up to 27
  - 252+8(i-27) up to 31
  - 284+6(i-31) up to 39
  - 332+5(i-39) up to 43
  - 352+4(i-43) up to 51
  - 384+2(i-51) up to 58
  - 400 above 58

  The magnitude code is floor((63q+200)/400). The polarity bit (1 = negative) is p[7]. Phase B uses position p+64.
- R5: In coarse mode (`coarse`=1) the stride is 32. The magnitude of position p depends on p[6:5]: 0 gives 0, 2 gives 63, and 1 or 3 gives 45. Polarity and the phase B offset are as in R4.
- R6: While `enable` is 0, both magnitudes and both polarity bits are 0. The position keeps following step edges, so re-enabling shows the advanced position.
- R7: While `park` is 1:
  - the position is forced to 0 on every clock and step edges are ignored;
  - the outputs show the initial state and `mon_n` is 0.
  
  After release, the next rising step edge moves the position from 0.
- R8: After a step that lands the position on 0 (`mon_quarter`=0), or on a multiple of 64 (`mon_quarter`=1), `mon_n` is 0 until the next tick.
- R9: After a step taken with `enable`=1 that lowers either phase's magnitude code, `step_down` is 1 until the next tick. Otherwise it is 0.
- R10: While enabled, at least one phase carries a magnitude code of 45 or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Internal time-base enable; state moves only when high |
| step_clk | input | 1 | Step clock; each rising edge is one step |
| enable | input | 1 | Excitation enable; 0 blanks the outputs |
| dir | input | 1 | 0 forward, 1 reverse |
| park | input | 1 | Hold at the initial position |
| coarse | input | 1 | 0 fine 256-step mode, 1 eight-step mode |
| mon_quarter | input | 1 | Monitor interval: 0 full turn, 1 quarter turn |
| mag_a | output | 6 | Phase A magnitude code |
| neg_a | output | 1 | Phase A polarity, 1 = negative |
| mag_b | output | 6 | Phase B magnitude code |
| neg_b | output | 1 | Phase B polarity, 1 = negative |
| mon_n | output | 1 | Active-low electrical-angle monitor |
| step_down | output | 1 | One-tick strobe on a magnitude decrease |

## Verification
The hardest situations to reach are those where position tracking and output gating part ways. One is steps taken while disabled, whose effect shows only after re-enable. The other is a step edge that arrives during park, which must be dropped without leaving a stale edge behind after release. The stimulus walks complete cycles in both directions and both resolutions, so every table index, zero crossing and wrap point is visited. A seeded random phase then mixes steps with enable toggles, mode and monitor changes, idle ticks and step-clock pulses that never see a tick, all checked against a bench model of the position.

// File: rtl/microstep_seq.sv
module microstep_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       step_clk,
  input  logic       enable,
  input  logic       dir,
  input  logic       park,
  input  logic       coarse,
  input  logic       mon_quarter,
  output logic [5:0] mag_a,
  output logic       neg_a,
  output logic [5:0] mag_b,
  output logic       neg_b,
  output logic       mon_n,
  output logic       step_down
);
  localparam int POS_W    = 8;
  localparam int QTR_W    = 6;
  localparam int MAG_W    = 6;
  localparam int FULL_Q   = 400;
  localparam int CODE_MAX = (1 << MAG_W) - 1;
  localparam logic [POS_W-1:0] QTR_OFS   = POS_W'(1 << QTR_W);
  localparam logic [POS_W-1:0] FINE_STR  = POS_W'(1);
  localparam logic [POS_W-1:0] COARSE_STR = POS_W'(1 << (QTR_W - 1));
  localparam logic [MAG_W-1:0] HALF_SQ   = MAG_W'(45);

  function automatic logic [8:0] qpct(input logic [QTR_W-1:0] i);
    logic [8:0] q;
    case (i)
      6'd0: q = 9'd10;   6'd1: q = 9'd20;   6'd2: q = 9'd30;   6'd3: q = 9'd40;
      6'd4: q = 9'd50;   6'd5: q = 9'd60;   6'd6: q = 9'd70;   6'd7: q = 9'd80;
      6'd8: q = 9'd89;   6'd9: q = 9'd98;   6'd10: q = 9'd107; 6'd11: q = 9'd116;
      6'd12: q = 9'd125; 6'd13: q = 9'd134; 6'd14: q = 9'd143; 6'd15: q = 9'd152;
      6'd16: q = 9'd161; 6'd17: q = 9'd170; 6'd18: q = 9'd179; 6'd19: q = 9'd188;
      6'd20: q = 9'd197; 6'd21: q = 9'd206; 6'd22: q = 9'd215; 6'd23: q = 9'd224;
      6'd24: q = 9'd231; 6'd25: q = 9'd238; 6'd26: q = 9'd245; 6'd27: q = 9'd252;
      6'd28: q = 9'd260; 6'd29: q = 9'd268; 6'd30: q = 9'd276; 6'd31: q = 9'd284;
      6'd32: q = 9'd290; 6'd33: q = 9'd296; 6'd34: q = 9'd302; 6'd35: q = 9'd308;
      6'd36: q = 9'd314; 6'd37: q = 9'd320; 6'd38: q = 9'd326; 6'd39: q = 9'd332;
      6'd40: q = 9'd337; 6'd41: q = 9'd342; 6'd42: q = 9'd347; 6'd43: q = 9'd352;
      6'd44: q = 9'd356; 6'd45: q = 9'd360; 6'd46: q = 9'd364; 6'd47: q = 9'd368;
      6'd48: q = 9'd372; 6'd49: q = 9'd376; 6'd50: q = 9'd380; 6'd51: q = 9'd384;
      6'd52: q = 9'd386; 6'd53: q = 9'd388; 6'd54: q = 9'd390; 6'd55: q = 9'd392;
      6'd56: q = 9'd394; 6'd57: q = 9'd396; 6'd58: q = 9'd398;
      default: q = 9'd400;
    endcase
    return q;
  endfunction

  function automatic logic [MAG_W-1:0] to_code(input logic [8:0] q);
    int v;
    v = (int'(q) * CODE_MAX + FULL_Q / 2) / FULL_Q;
    return MAG_W'(v);
  endfunction

  function automatic logic [MAG_W-1:0] mag_at(input logic [POS_W-1:0] p, input logic crs);
    logic [MAG_W-1:0] m;
    if (crs) begin
      case (p[QTR_W:QTR_W-1])
        2'd0:    m = '0;
        2'd2:    m = MAG_W'(CODE_MAX);
        default: m = HALF_SQ;
      endcase
    end else begin
      m = to_code(qpct(p[QTR_W] ? ~p[QTR_W-1:0] : p[QTR_W-1:0]));
    end
    return m;
  endfunction

  logic [POS_W-1:0] pos;
  logic             sc_q, mon_r, dn_r;

  logic             rise;
  logic [POS_W-1:0] stride, nxt, shown, shown_b;
  logic [MAG_W-1:0] cur_a, cur_b, nxt_a, nxt_b;

  assign rise    = tick & step_clk & ~sc_q;
  assign stride  = coarse ? COARSE_STR : FINE_STR;
  assign nxt     = dir ? pos - stride : pos + stride;
  assign cur_a   = mag_at(pos, coarse);
  assign cur_b   = mag_at(pos + QTR_OFS, coarse);
  assign nxt_a   = mag_at(nxt, coarse);
  assign nxt_b   = mag_at(nxt + QTR_OFS, coarse);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= '0;
      sc_q  <= 1'b0;
      mon_r <= 1'b0;
      dn_r  <= 1'b0;
    end else if (park) begin
      pos   <= '0;
      mon_r <= 1'b0;
      dn_r  <= 1'b0;
      if (tick) sc_q <= step_clk;
    end else if (tick) begin
      sc_q  <= step_clk;
      mon_r <= rise && (mon_quarter ? (nxt[QTR_W-1:0] == '0) : (nxt == '0));
      dn_r  <= rise && enable && ((nxt_a < cur_a) || (nxt_b < cur_b));
      if (rise) pos <= nxt;
    end
  end

  assign shown     = park ? '0 : pos;
  assign shown_b   = shown + QTR_OFS;
  assign mag_a     = enable ? mag_at(shown, coarse) : '0;
  assign mag_b     = enable ? mag_at(shown_b, coarse) : '0;
  assign neg_a     = enable & shown[POS_W-1];
  assign neg_b     = enable & shown_b[POS_W-1];
  assign mon_n     = ~(park | mon_r);
  assign step_down = dn_r;

  a_r2_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !park) |=> $stable(pos));

  a_r3_edge_moves: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && step_clk && !sc_q && !park) |=> (pos != $past(pos)));

  a_r7_park_initial: assert property (@(posedge clk) disable iff (!rst_n)
    park |=> (pos == '0));

  a_r9_strobe_one_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && step_down && !(step_clk && !sc_q)) |=> !step_down);

  a_r10_one_phase_strong: assert property (@(posedge clk) disable iff (!rst_n)
    enable |-> ((mag_a >= HALF_SQ) || (mag_b >= HALF_SQ)));
endmodule

// File: tb/sim_microstep_seq.sv
module sim_microstep_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, step_clk = 1'b0, enable = 1'b1, dir = 1'b0;
  logic park = 1'b0, coarse = 1'b0, mon_quarter = 1'b0;
  logic [5:0] mag_a, mag_b;
  logic neg_a, neg_b, mon_n, step_down;

  int checks = 0, bad = 0, mp = 0;
  bit done = 0;

  always #2 clk = ~clk;

  microstep_seq u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .step_clk(step_clk), .enable(enable),
    .dir(dir), .park(park), .coarse(coarse), .mon_quarter(mon_quarter),
    .mag_a(mag_a), .neg_a(neg_a), .mag_b(mag_b), .neg_b(neg_b),
    .mon_n(mon_n), .step_down(step_down)
  );

  function automatic int qb(int i);
    if (i <= 7)  return 10 * (i + 1);
    if (i <= 23) return 80 + 9 * (i - 7);
    if (i <= 27) return 224 + 7 * (i - 23);
    if (i <= 31) return 252 + 8 * (i - 27);
    if (i <= 39) return 284 + 6 * (i - 31);
    if (i <= 43) return 332 + 5 * (i - 39);
    if (i <= 51) return 352 + 4 * (i - 43);
    if (i <= 58) return 384 + 2 * (i - 51);
    return 400;
  endfunction

  function automatic int cd(int q);
    return (q * 63 + 200) / 400;
  endfunction

  function automatic int emag(int p, bit crs);
    int k, i;
    p = p & 255;
    if (crs) begin
      k = (p >> 5) & 3;
      if (k == 0) return 0;
      if (k == 2) return 63;
      return cd(qb(31));
    end
    i = p & 63;
    if ((p & 64) != 0) i = 63 - i;
    return cd(qb(i));
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic chk_out(string req, bit xmon, bit xdn);
    int sp;
    sp = park ? 0 : mp;
    chk(req, int'(mag_a), enable ? emag(sp, coarse) : 0);
    chk(req, int'(neg_a), enable ? ((sp >> 7) & 1) : 0);
    chk(req, int'(mag_b), enable ? emag(sp + 64, coarse) : 0);
    chk(req, int'(neg_b), enable ? (((sp + 64) >> 7) & 1) : 0);
    chk("R8", int'(mon_n), (park || xmon) ? 0 : 1);
    chk("R9", int'(step_down), int'(xdn));
    if (enable) chk("R10", int'((mag_a >= 6'd45) || (mag_b >= 6'd45)), 1);
  endtask

  task automatic tick_once(input logic sc);
    @(negedge clk);
    step_clk = sc;
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_step(string req, bit d);
    int old, st, nw;
    bit xm, xd;
    old = mp;
    st = coarse ? 32 : 1;
    xm = 0;
    xd = 0;
    dir = d;
    tick_once(1'b1);
    if (!park) begin
      nw = (d ? old - st : old + st) & 255;
      xm = mon_quarter ? ((nw % 64) == 0) : (nw == 0);
      xd = enable && ((emag(nw, coarse) < emag(old, coarse)) ||
                      (emag(nw + 64, coarse) < emag(old + 64, coarse)));
      mp = nw;
    end
    chk_out(req, xm, xd);
    tick_once(1'b0);
    chk_out(req, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      checks++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed0;
    seed0 = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", int'(mag_a), 2);
    chk("R1", int'(mag_b), 63);
    chk("R1", int'(neg_a), 0);
    chk("R1", int'(neg_b), 0);
    chk("R1", int'(mon_n), 1);
    chk("R1", int'(step_down), 0);

    // R2 step clock high without tick, then ticks without a new edge
    step_clk = 1'b1;
    repeat (3) @(negedge clk);
    step_clk = 1'b0;
    @(negedge clk);
    chk_out("R2", 0, 0);
    tick_once(1'b0);
    tick_once(1'b0);
    chk_out("R2", 0, 0);

    // R4 and R3: fine mode full cycle forward then reverse
    mon_quarter = 1'b0;
    for (int n = 0; n < 256; n++) do_step("R4", 1'b0);
    mon_quarter = 1'b1;
    for (int n = 0; n < 256; n++) do_step("R3", 1'b1);

    // R5 coarse mode both directions
    coarse = 1'b1;
    for (int n = 0; n < 8; n++) do_step("R5", 1'b0);
    mon_quarter = 1'b0;
    for (int n = 0; n < 8; n++) do_step("R5", 1'b1);
    coarse = 1'b0;

    // R6 disabled steps keep tracking
    enable = 1'b0;
    for (int n = 0; n < 5; n++) do_step("R6", 1'b0);
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    chk_out("R6", 0, 0);
    chk("R6", int'(mag_a), emag(5, 1'b0));

    // R7 park: initial state, edges ignored, resume from 0
    for (int n = 0; n < 20; n++) do_step("R7", 1'b0);
    park = 1'b1;
    @(negedge clk);
    mp = 0;
    chk_out("R7", 0, 0);
    do_step("R7", 1'b0);
    do_step("R7", 1'b0);
    park = 1'b0;
    @(negedge clk);
    chk_out("R7", 0, 0);
    do_step("R7", 1'b0);
    chk("R7", int'(mag_a), emag(1, 1'b0));

    // random mix
    for (int n = 0; n < 800; n++) begin
      int op;
      op = int'($urandom_range(0, 9));
      if (op <= 4) do_step("R3", 1'($urandom_range(0, 1)));
      else if (op == 5) begin
        @(negedge clk);
        enable = ~enable;
        @(negedge clk);
        chk_out("R6", 0, 0);
      end else if (op == 6) begin
        @(negedge clk);
        coarse = 1'($urandom_range(0, 1));
        mon_quarter = 1'($urandom_range(0, 1));
        @(negedge clk);
        chk_out("R5", 0, 0);
      end else if (op == 7) begin
        tick_once(1'b0);
        chk_out("R2", 0, 0);
      end else if (op == 8) begin
        @(negedge clk);
        step_clk = 1'b1;
        @(negedge clk);
        step_clk = 1'b0;
        @(negedge clk);
        chk_out("R2", 0, 0);
      end else begin
        park = 1'b1;
        @(negedge clk);
        mp = 0;
        chk_out("R7", 0, 0);
        park = 1'b0;
        @(negedge clk);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule